// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block is a small word-addressed memory shared by several requesters. Each requester presents an operation code, a word address, a compare operand and a new-value operand. Besides plain load and store, the memory executes two indivisible read-modify-write operations. The first is a lock acquire (test-and-set). The second is a conditional replace (compare-and-swap). Each of these reads the word, decides, and writes the word back without any other access in between.

A round-robin arbiter picks at most one request per cycle. The grant is shown combinationally on the requester's grant line in the same cycle. The granted operation reads the word and commits any write in that one slot, so the next granted operation already sees its result. The old word and a success flag return to the granted requester one cycle later. Software builds locks in two ways. It can spin on test-and-set until the flag reports that the lock was free, then release the lock with a store of zero. Or it can read a word, compute a new one and compare-and-swap it in, retrying when the returned old value is not the one it expected.

Top module: `atomic_mem_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, no response valid bit is high.
- R2: Opcode 2'b00 (load) leaves memory unchanged. Its response carries the addressed word with the success flag set to 1.
- R3: Opcode 2'b01 (store) writes the new-value operand to the address. Its response carries the word that was there before, with the success flag set to 1.
- R4: Opcode 2'b10 (test-and-set) on a word equal to zero writes 1 to the word. Its response carries 0 with the success flag set to 1.
- R5: Opcode 2'b10 on a nonzero word leaves the word unchanged. Its response carries the old word with the success flag set to 0. A store of zero then releases the lock.
- R6: Opcode 2'b11 (compare-and-swap) whose compare operand equals the word writes the new-value operand. Its response carries the old word, which equals the compare operand, with the success flag set to 1.
- R7: Opcode 2'b11 whose compare operand differs from the word leaves the word unchanged. Its response carries the old word with the success flag set to 0.
- R8: At most one grant is high per cycle, and only on a port whose request valid is high.
- R9: A response valid bit rises exactly one cycle after a grant, on the granted port only. No response valid bit is high in a cycle that follows a cycle without a grant.
- R10: The grant rotates. After port p is granted, priority starts at port p+1 (wrapping to port 0 after the last port), so a granted port loses to any other port requesting in the next cycle. Priority starts at port 0 after reset.
- R11: Atomic operations are serialized. When all ports test-and-set the same free lock word at once, exactly one of them succeeds. Each later operation sees the value written by the one granted before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_PORTS | Request valid per port, held until granted |
| req_op | input | 2*NUM_PORTS | Opcode per port (00 load, 01 store, 10 test-and-set, 11 compare-and-swap) |
| req_addr | input | ADDR_W*NUM_PORTS | Word address per port |
| req_cmp | input | DATA_W*NUM_PORTS | Compare operand per port |
| req_wdata | input | DATA_W*NUM_PORTS | New-value operand per port |
| req_grant | output | NUM_PORTS | One-hot grant, same cycle as the request is taken |
| rsp_valid | output | NUM_PORTS | Response valid per port, one cycle after grant |
| rsp_data | output | DATA_W | Old memory word of the granted operation |
| rsp_ok | output | 1 | Success flag of the granted operation |

## Verification
A wrong rotation pointer shows at once as a grant on an unexpected port, which is compared against an independent model every cycle. A wrong memory word, or a write that lands when it should not or is lost when it should land, stays hidden until that address is next touched. The response of that later access then shows the wrong old value or a wrong success flag. To keep that delay to a few cycles, random traffic is confined to four addresses. A lost or misrouted response valid bit shows on the very next cycle.

// File: rtl/atomic_mem_pkg.sv
package atomic_mem_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_TAS   = 2'b10,
    OP_CAS   = 2'b11
  } mem_op_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int NUM_PORTS = 3,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] gnt,
  output logic [PW-1:0]        gnt_idx,
  output logic                 gnt_any
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          armed_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      int cand;
      cand = int'(ptr_q) + k;
      if (cand >= NUM_PORTS) cand = cand - NUM_PORTS;
      if (!gnt_any && req[cand]) begin
        gnt_any   = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = PW'(cand);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (gnt_any) begin
      if (gnt_idx == PW'(NUM_PORTS - 1)) ptr_d = '0;
      else                               ptr_d = gnt_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (gnt_any) ptr_q <= ptr_d;
    end
  end

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_to_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fair
    assert_rotate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $past(gnt[p]) && ((req & ~(NUM_PORTS'(1) << p)) != '0)) |-> !gnt[p]);
  end
endmodule

// File: rtl/rmw_exec.sv
module rmw_exec
  import atomic_mem_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  mem_op_e           op,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic [DATA_W-1:0] new_val,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_word,
  output logic              ok
);
  always_comb begin
    wr_en   = 1'b0;
    wr_word = new_val;
    ok      = 1'b1;
    unique case (op)
      OP_LOAD: begin
        wr_en = 1'b0;
        ok    = 1'b1;
      end
      OP_STORE: begin
        wr_en = 1'b1;
        ok    = 1'b1;
      end
      OP_TAS: begin
        ok      = (old_word == '0);
        wr_en   = ok;
        wr_word = DATA_W'(1);
      end
      OP_CAS: begin
        ok    = (old_word == cmp_val);
        wr_en = ok;
      end
      default: begin
        wr_en = 1'b0;
        ok    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              armed_q;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(wr_en)) |-> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import atomic_mem_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req_valid,
  input  logic [2*NUM_PORTS-1:0]      req_op,
  input  logic [ADDR_W*NUM_PORTS-1:0] req_addr,
  input  logic [DATA_W*NUM_PORTS-1:0] req_cmp,
  input  logic [DATA_W*NUM_PORTS-1:0] req_wdata,
  output logic [NUM_PORTS-1:0]        req_grant,
  output logic [NUM_PORTS-1:0]        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        rsp_ok
);
  logic [NUM_PORTS-1:0] gnt;
  logic [PW-1:0]        gnt_idx;
  logic                 gnt_any;
  mem_op_e              sel_op;
  logic [ADDR_W-1:0]    sel_addr;
  logic [DATA_W-1:0]    sel_cmp, sel_wdata, old_word, wr_word;
  logic                 exec_we, exec_ok, wr_en;

  logic [NUM_PORTS-1:0] rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0]    rsp_data_q, rsp_data_d;
  logic                 rsp_ok_q, rsp_ok_d, armed_q;

  rr_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  always_comb begin
    sel_op    = mem_op_e'(req_op[gnt_idx*2 +: 2]);
    sel_addr  = req_addr[gnt_idx*ADDR_W +: ADDR_W];
    sel_cmp   = req_cmp[gnt_idx*DATA_W +: DATA_W];
    sel_wdata = req_wdata[gnt_idx*DATA_W +: DATA_W];
  end

  rmw_exec #(.DATA_W(DATA_W)) u_exec (
    .op(sel_op), .old_word(old_word), .cmp_val(sel_cmp), .new_val(sel_wdata),
    .wr_en(exec_we), .wr_word(wr_word), .ok(exec_ok)
  );

  assign wr_en = gnt_any & exec_we;

  word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(sel_addr), .rd_data(old_word),
    .wr_en(wr_en), .wr_addr(sel_addr), .wr_data(wr_word)
  );

  always_comb begin
    rsp_valid_d = gnt;
    rsp_data_d  = gnt_any ? old_word : rsp_data_q;
    rsp_ok_d    = gnt_any ? exec_ok  : rsp_ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
      rsp_ok_q    <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      armed_q     <= 1'b1;
      rsp_valid_q <= rsp_valid_d;
      if (gnt_any) begin
        rsp_data_q <= rsp_data_d;
        rsp_ok_q   <= rsp_ok_d;
      end
    end
  end

  assign req_grant = gnt;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_ok    = rsp_ok_q;

  assert_rsp_follows_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (rsp_valid == $past(req_grant)));
  assert_rsp_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
endmodule

// File: tb/tb_atomic_mem_unit.sv
module tb_atomic_mem_unit;
  localparam int N  = 3;
  localparam int DW = 32;
  localparam int D  = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [N-1:0]    req_valid;
  logic [2*N-1:0]  req_op;
  logic [AW*N-1:0] req_addr;
  logic [DW*N-1:0] req_cmp, req_wdata;
  logic [N-1:0]    req_grant, rsp_valid;
  logic [DW-1:0]   rsp_data;
  logic            rsp_ok;

  logic          pv  [N];
  logic [1:0]    pop [N];
  logic [AW-1:0] padr[N];
  logic [DW-1:0] pcmp[N], pwd[N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]            = pv[i];
      req_op[i*2 +: 2]        = pop[i];
      req_addr[i*AW +: AW]    = padr[i];
      req_cmp[i*DW +: DW]     = pcmp[i];
      req_wdata[i*DW +: DW]   = pwd[i];
    end
  end

  atomic_mem_unit #(.NUM_PORTS(N), .DATA_W(DW), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_cmp(req_cmp), .req_wdata(req_wdata),
    .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  int unsigned   n_tests = 0, n_fail = 0;
  logic [DW-1:0] model [D];
  int            rr_ptr = 0;
  logic          last_ok [N];

  function automatic string op_tag(input logic [1:0] op, input logic ok);
    case (op)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return ok ? "R4" : "R5";
      default: return ok ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already set at this negedge
  task automatic tick();
    int            gi;
    logic [N-1:0]  egnt;
    logic [DW-1:0] old;
    logic          ok;
    logic [1:0]    op;
    #1;
    gi = -1;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (rr_ptr + k) % N;
      if (gi < 0 && pv[c]) gi = c;
    end
    egnt = (gi >= 0) ? (N'(1) << gi) : '0;
    check(req_grant == egnt, "R8 R10 grant", 64'(req_grant), 64'(egnt));
    old = '0; ok = 1'b0; op = 2'b00;
    if (gi >= 0) begin
      op  = pop[gi];
      old = model[padr[gi]];
      case (op)
        2'b00: ok = 1'b1;
        2'b01: begin ok = 1'b1; model[padr[gi]] = pwd[gi]; end
        2'b10: begin ok = (old == 0); if (ok) model[padr[gi]] = 1; end
        default: begin ok = (old == pcmp[gi]); if (ok) model[padr[gi]] = pwd[gi]; end
      endcase
      rr_ptr = (gi + 1) % N;
    end
    @(negedge clk);
    check(rsp_valid == egnt, "R9 rsp_valid", 64'(rsp_valid), 64'(egnt));
    if (gi >= 0) begin
      check(rsp_data == old, {op_tag(op, ok), " rsp_data"}, 64'(rsp_data), 64'(old));
      check(rsp_ok == ok, {op_tag(op, ok), " rsp_ok"}, 64'(rsp_ok), 64'(ok));
      last_ok[gi] = rsp_ok;
      pv[gi] = 1'b0;
    end
  endtask

  task automatic issue(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] c, input logic [DW-1:0] w);
    pv[p] = 1'b1; pop[p] = op; padr[p] = a; pcmp[p] = c; pwd[p] = w;
  endtask

  task automatic drain();
    while (pv[0] || pv[1] || pv[2]) tick();
  endtask

  function automatic logic [DW-1:0] rnd_val();
    int unsigned r;
    r = $urandom % 4;
    if (r == 0) return '0;
    if (r == 1) return 32'd1;
    return $urandom;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin
      pv[i] = 0; pop[i] = 0; padr[i] = 0; pcmp[i] = 0; pwd[i] = 0; last_ok[i] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid == '0, "R1 during reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == '0, "R1 after reset", 64'(rsp_valid), 64'd0);

    // fill every word (R3)
    for (int a = 0; a < D; a++) begin
      issue(0, 2'b01, AW'(a), '0, 32'(a * 7 + 3));
      tick();
    end
    // load (R2), twice to show it is unchanged
    issue(1, 2'b00, 4'd3, '0, '0); tick();
    issue(1, 2'b00, 4'd3, '0, '0); tick();
    // lock: free -> take (R4), held -> fail (R5), release by storing zero, take again
    issue(0, 2'b01, 4'd5, '0, '0); tick();
    issue(2, 2'b10, 4'd5, '0, '0); tick();
    issue(2, 2'b10, 4'd5, '0, '0); tick();
    issue(1, 2'b01, 4'd5, '0, '0); tick();
    issue(1, 2'b10, 4'd5, '0, '0); tick();
    // conditional replace: match (R6), stale compare (R7), readback
    issue(0, 2'b11, 4'd7, 32'd52, 32'hCAFE); tick();
    issue(0, 2'b11, 4'd7, 32'd52, 32'hBEEF); tick();
    issue(0, 2'b00, 4'd7, '0, '0); tick();
    // R11: all ports race for one free lock
    issue(0, 2'b01, 4'd9, '0, '0); tick();
    for (int p = 0; p < N; p++) issue(p, 2'b10, 4'd9, '0, '0);
    drain();
    begin
      int wins;
      wins = 0;
      for (int p = 0; p < N; p++) wins += int'(last_ok[p]);
      check(wins == 1, "R11 single winner", 64'(wins), 64'd1);
    end
    // R10: all ports store at once, rotation order checked per cycle
    for (int p = 0; p < N; p++) issue(p, 2'b01, 4'd10, '0, 32'(p + 100));
    drain();

    // random traffic on four contended words
    for (int it = 0; it < 3000; it++) begin
      for (int p = 0; p < N; p++) begin
        if (!pv[p] && ($urandom % 2 == 0)) begin
          logic [AW-1:0] a;
          logic [DW-1:0] c;
          a = AW'($urandom % 4);
          c = ($urandom % 2 == 0) ? model[a] : rnd_val();
          issue(p, 2'($urandom % 4), a, c, rnd_val());
        end
      end
      tick();
    end
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule